// File: doc/BRIEF.md
# Segmented Physical Address Generator

This combinational block turns a segment and an offset into a byte address for a 16-bit processor that uses segmented memory. The caller supplies the four segment values (code, stack, data, extra), the base registers BX and BP, the index registers SI and DI, the instruction pointer, the stack pointer and a displacement. It also gives a request kind, an addressing-mode code and an optional segment override. The block returns the 16-bit effective address, the segment it picked and the 20-bit physical address.

The physical address is the chosen segment shifted left by four bits plus the effective address. The segment is chosen in this order:

- It follows from the request kind (code fetch, stack top, string destination).
- For data operands it follows from the base register of the addressing form.
- An explicit override on a data operand replaces that default.

The block keeps no state. It does not decode instructions, hold register contents or drive a bus.

Top module: `seg_addr_gen`

## Requirements
- R1: `pa_o` equals (segment value × 16 + `ea_o`) modulo 2^20, where the segment value is the one named by `seg_sel_o`. The `seg_sel_o` codes are 0 = extra, 1 = code, 2 = stack, 3 = data.
- R2: With `req_i` = 0 (code fetch), `ea_o` equals `ip_i` and the code segment is selected. `mode_i`, `ovr_i` and `disp_i` have no effect.
- R3: With `req_i` = 1 (stack top), `ea_o` equals `sp_i` and the stack segment is selected. `ovr_i` and `mode_i` have no effect.
- R4: With `req_i` = 2 (data operand), `mode_i[3:2]` selects the effective-address form and `mode_i[1:0]` selects the registers:
  - Group 0: low code 0 gives the direct offset `disp_i`; low codes 1, 2 and 3 give BX, SI and DI.
  - Group 1: BX, BP, SI or DI (low code 0 to 3), plus the displacement.
  - Group 2: base (bit 1: 0 = BX, 1 = BP) plus index (bit 0: 0 = SI, 1 = DI).
  - Group 3: as group 2, plus the displacement.
- R5: A data operand whose form uses BP as base (group 1 low code 1, or groups 2 and 3 with bit 1 set) defaults to the stack segment. Every other data form, including the direct offset, defaults to the data segment.
- R6: With `req_i` = 3 (string destination), `ea_o` equals `di_i` and the extra segment is selected. `ovr_i` and `mode_i` have no effect.
- R7: For a legal data operand with `ovr_i[2]` = 1, the segment named by `ovr_i[1:0]` (same codes as R1) replaces the default. With `ovr_i[2]` = 0 the default stands.
- R8: With `disp_wide_i` = 1 the displacement is all 16 bits of `disp_i`. With `disp_wide_i` = 0 it is `disp_i[7:0]` sign-extended to 16 bits. The direct offset of group 0 always uses all 16 bits.
- R9: The effective-address sum wraps modulo 2^16, and the physical-address sum wraps modulo 2^20.
- R10: A data operand with `mode_i[4]` = 1 is illegal. It gives `ea_o` = 0 and the data segment, whatever `ovr_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cs_i | input | 16 | Code segment value |
| ss_i | input | 16 | Stack segment value |
| ds_i | input | 16 | Data segment value |
| es_i | input | 16 | Extra segment value |
| bx_i | input | 16 | Base register BX |
| bp_i | input | 16 | Base pointer BP |
| si_i | input | 16 | Source index SI |
| di_i | input | 16 | Destination index DI |
| ip_i | input | 16 | Instruction pointer |
| sp_i | input | 16 | Stack pointer |
| disp_i | input | 16 | Displacement or direct offset |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = sign-extended 8-bit |
| mode_i | input | 5 | Addressing-mode code for data operands |
| ovr_i | input | 3 | Override enable (bit 2) and segment code (bits 1:0) |
| req_i | input | 2 | Request kind: fetch, stack, data, string destination |
| ea_o | output | 16 | Effective address |
| seg_sel_o | output | 2 | Selected segment code |
| pa_o | output | 20 | 20-bit physical address |

## Verification
The bench builds the block with its default parameters: 16-bit segments and offsets, a four-bit segment shift and an 8-bit short displacement. With these values the control space is small enough to cover in full. The sweep applies every request kind, all 32 mode codes (illegal ones included), all 8 override codes and both displacement sizes. It repeats this for three register sets: one aligned with the worked vectors, one that drives both sums past their wrap points, and one whose short displacement has its sign bit set. Two hand-checked vectors then pin the based-indexed-plus-displacement case and the BP-relative case to known physical addresses.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   // Segment identifiers; also the override code in ovr_i[1:0]
   typedef enum logic [1:0] {
      SEG_ES = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_DS = 2'd3
   } seg_id_e;

   // Kind of address the caller wants
   typedef enum logic [1:0] {
      REQ_FETCH  = 2'd0,
      REQ_STACK  = 2'd1,
      REQ_DATA   = 2'd2,
      REQ_STRDST = 2'd3
   } req_e;

   // Mode group in mode[3:2]
   localparam logic [1:0] GRP_PLAIN = 2'd0;  // direct / register indirect
   localparam logic [1:0] GRP_REL   = 2'd1;  // register + displacement
   localparam logic [1:0] GRP_BI    = 2'd2;  // base + index
   localparam logic [1:0] GRP_BID   = 2'd3;  // base + index + displacement

   localparam int OVR_W = 3;

endpackage

// File: rtl/seg_ea_unit.sv
module seg_ea_unit
   import seg_addr_pkg::*;
#(
   parameter int OFS_W    = 16,
   parameter int DSHORT_W = 8,
   parameter int MODE_W   = 5
) (
   input  logic [OFS_W-1:0]  bx_i,
   input  logic [OFS_W-1:0]  bp_i,
   input  logic [OFS_W-1:0]  si_i,
   input  logic [OFS_W-1:0]  di_i,
   input  logic [OFS_W-1:0]  disp_i,
   input  logic              disp_wide_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [OFS_W-1:0]  ea_o,
   output logic              uses_bp_o,
   output logic              legal_o
);

   localparam int EXT_W = OFS_W - DSHORT_W;

   if (MODE_W < 5) begin : g_bad_mode
      $error("seg_ea_unit: MODE_W must be at least 5");
   end
   if (DSHORT_W < 1 || DSHORT_W >= OFS_W) begin : g_bad_dshort
      $error("seg_ea_unit: DSHORT_W must lie in 1..OFS_W-1");
   end

   logic [OFS_W-1:0] disp_ext;
   logic [OFS_W-1:0] term_a, term_b, term_c;
   logic [1:0]       grp, low;
   logic             illegal;

   // Short displacement sign-extended to the offset width
   always_comb begin
      if (disp_wide_i) disp_ext = disp_i;
      else             disp_ext = {{EXT_W{disp_i[DSHORT_W-1]}}, disp_i[DSHORT_W-1:0]};
   end

   assign grp     = mode_i[3:2];
   assign low     = mode_i[1:0];
   assign illegal = |mode_i[MODE_W-1:4];

   always_comb begin
      term_a    = '0;
      term_b    = '0;
      term_c    = '0;
      uses_bp_o = 1'b0;
      case (grp)
         GRP_PLAIN: begin
            case (low)
               2'd0:    term_a = disp_i;
               2'd1:    term_a = bx_i;
               2'd2:    term_a = si_i;
               default: term_a = di_i;
            endcase
         end
         GRP_REL: begin
            case (low)
               2'd0:    term_a = bx_i;
               2'd1:    term_a = bp_i;
               2'd2:    term_a = si_i;
               default: term_a = di_i;
            endcase
            term_c    = disp_ext;
            uses_bp_o = (low == 2'd1);
         end
         default: begin
            term_a    = low[1] ? bp_i : bx_i;
            term_b    = low[0] ? di_i : si_i;
            term_c    = (grp == GRP_BID) ? disp_ext : '0;
            uses_bp_o = low[1];
         end
      endcase
      if (illegal) begin
         term_a    = '0;
         term_b    = '0;
         term_c    = '0;
         uses_bp_o = 1'b0;
      end
   end

   // Sum wraps modulo 2^OFS_W
   assign ea_o    = term_a + term_b + term_c;
   assign legal_o = !illegal;

   always_comb begin
      p_illegal_zero_r10: assert (legal_o || (ea_o == '0))
         else $error("illegal mode produced nonzero EA");
      p_bp_only_legal_r5: assert (legal_o || !uses_bp_o)
         else $error("illegal mode flagged BP base");
   end

endmodule

// File: rtl/seg_req_route.sv
module seg_req_route
   import seg_addr_pkg::*;
#(
   parameter int OFS_W = 16
) (
   input  logic [1:0]       req_i,
   input  logic [OVR_W-1:0] ovr_i,
   input  logic [OFS_W-1:0] data_ea_i,
   input  logic             data_uses_bp_i,
   input  logic             data_legal_i,
   input  logic [OFS_W-1:0] ip_i,
   input  logic [OFS_W-1:0] sp_i,
   input  logic [OFS_W-1:0] di_i,
   output logic [OFS_W-1:0] ea_o,
   output seg_id_e          seg_o
);

   seg_id_e data_seg;

   // Illegal forms ignore override, then override, then base-register default
   always_comb begin
      if (!data_legal_i)  data_seg = SEG_DS;
      else if (ovr_i[2])  data_seg = seg_id_e'(ovr_i[1:0]);
      else if (data_uses_bp_i) data_seg = SEG_SS;
      else                data_seg = SEG_DS;
   end

   always_comb begin
      case (req_e'(req_i))
         REQ_FETCH:  begin ea_o = ip_i;      seg_o = SEG_CS;   end
         REQ_STACK:  begin ea_o = sp_i;      seg_o = SEG_SS;   end
         REQ_STRDST: begin ea_o = di_i;      seg_o = SEG_ES;   end
         default:    begin ea_o = data_ea_i; seg_o = data_seg; end
      endcase
   end

   always_comb begin
      p_fetch_cs_r2: assert (req_i != REQ_FETCH || (seg_o == SEG_CS && ea_o == ip_i))
         else $error("fetch not CS:IP");
      p_stack_ss_r3: assert (req_i != REQ_STACK || (seg_o == SEG_SS && ea_o == sp_i))
         else $error("stack not SS:SP");
      p_strdst_es_r6: assert (req_i != REQ_STRDST || (seg_o == SEG_ES && ea_o == di_i))
         else $error("string destination not ES:DI");
   end

endmodule

// File: rtl/seg_pa_adder.sv
module seg_pa_adder
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter int OFS_W = 16,
   parameter int SHIFT = 4
) (
   input  seg_id_e          seg_i,
   input  logic [SEG_W-1:0] cs_i,
   input  logic [SEG_W-1:0] ss_i,
   input  logic [SEG_W-1:0] ds_i,
   input  logic [SEG_W-1:0] es_i,
   input  logic [OFS_W-1:0] ea_i,
   output logic [SEG_W+SHIFT-1:0] pa_o
);

   localparam int PA_W = SEG_W + SHIFT;

   if (SHIFT < 1) begin : g_bad_shift
      $error("seg_pa_adder: SHIFT must be at least 1");
   end
   if (PA_W <= OFS_W) begin : g_bad_width
      $error("seg_pa_adder: shifted segment must be wider than the offset");
   end

   logic [SEG_W-1:0] seg_tab [4];
   logic [SEG_W-1:0] seg_val;
   logic [PA_W-1:0]  seg_sh, ea_ext;

   assign seg_tab[SEG_ES] = es_i;
   assign seg_tab[SEG_CS] = cs_i;
   assign seg_tab[SEG_SS] = ss_i;
   assign seg_tab[SEG_DS] = ds_i;
   assign seg_val         = seg_tab[seg_i];

   assign seg_sh = {seg_val, {SHIFT{1'b0}}};
   assign ea_ext = {{(PA_W-OFS_W){1'b0}}, ea_i};

   // Wraps modulo 2^PA_W
   assign pa_o = seg_sh + ea_ext;

   always_comb begin
      p_pa_low_bits_r1: assert (pa_o[SHIFT-1:0] == ea_i[SHIFT-1:0])
         else $error("PA low bits differ from EA");
   end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int SEG_W    = 16,
   parameter int OFS_W    = 16,
   parameter int SHIFT    = 4,
   parameter int DSHORT_W = 8,
   parameter int MODE_W   = 5
) (
   input  logic [SEG_W-1:0]       cs_i,
   input  logic [SEG_W-1:0]       ss_i,
   input  logic [SEG_W-1:0]       ds_i,
   input  logic [SEG_W-1:0]       es_i,
   input  logic [OFS_W-1:0]       bx_i,
   input  logic [OFS_W-1:0]       bp_i,
   input  logic [OFS_W-1:0]       si_i,
   input  logic [OFS_W-1:0]       di_i,
   input  logic [OFS_W-1:0]       ip_i,
   input  logic [OFS_W-1:0]       sp_i,
   input  logic [OFS_W-1:0]       disp_i,
   input  logic                   disp_wide_i,
   input  logic [MODE_W-1:0]      mode_i,
   input  logic [OVR_W-1:0]       ovr_i,
   input  logic [1:0]             req_i,
   output logic [OFS_W-1:0]       ea_o,
   output logic [1:0]             seg_sel_o,
   output logic [SEG_W+SHIFT-1:0] pa_o
);

   logic [OFS_W-1:0] data_ea;
   logic             data_uses_bp, data_legal;
   seg_id_e          seg_sel;

   seg_ea_unit #(.OFS_W(OFS_W), .DSHORT_W(DSHORT_W), .MODE_W(MODE_W)) u_ea (
      .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
      .disp_i(disp_i), .disp_wide_i(disp_wide_i), .mode_i(mode_i),
      .ea_o(data_ea), .uses_bp_o(data_uses_bp), .legal_o(data_legal)
   );

   seg_req_route #(.OFS_W(OFS_W)) u_route (
      .req_i(req_i), .ovr_i(ovr_i),
      .data_ea_i(data_ea), .data_uses_bp_i(data_uses_bp), .data_legal_i(data_legal),
      .ip_i(ip_i), .sp_i(sp_i), .di_i(di_i),
      .ea_o(ea_o), .seg_o(seg_sel)
   );

   seg_pa_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_pa (
      .seg_i(seg_sel), .cs_i(cs_i), .ss_i(ss_i), .ds_i(ds_i), .es_i(es_i),
      .ea_i(ea_o), .pa_o(pa_o)
   );

   assign seg_sel_o = seg_sel;

   always_comb begin
      p_ovr_applied_r7: assert (!(req_i == REQ_DATA && data_legal && ovr_i[2]) ||
                                (seg_sel_o == ovr_i[1:0]))
         else $error("override not applied");
      p_data_default_r5: assert (!(req_i == REQ_DATA && !ovr_i[2]) ||
                                 (seg_sel_o == (data_uses_bp ? SEG_SS : SEG_DS)))
         else $error("default data segment wrong");
   end

endmodule

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;

   localparam int CLK_P = 10;

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic [15:0] cs, ss, ds, es, bx, bp, si, di, ip, sp, disp;
   logic        wide;
   logic [4:0]  mode;
   logic [2:0]  ovr;
   logic [1:0]  req;
   logic [15:0] ea;
   logic [1:0]  seg;
   logic [19:0] pa;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   seg_addr_gen dut_i (
      .cs_i(cs), .ss_i(ss), .ds_i(ds), .es_i(es),
      .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di), .ip_i(ip), .sp_i(sp),
      .disp_i(disp), .disp_wide_i(wide), .mode_i(mode), .ovr_i(ovr), .req_i(req),
      .ea_o(ea), .seg_sel_o(seg), .pa_o(pa)
   );

   // Expected {seg, ea, pa} from the requirements
   function automatic logic [37:0] expect_addr();
      logic [15:0] dx, e, sv;
      logic [1:0]  s, g, l;
      logic        bpb;
      dx  = wide ? disp : {{8{disp[7]}}, disp[7:0]};
      g   = mode[3:2];
      l   = mode[1:0];
      bpb = 1'b0;
      if (req == 2'd0)      begin e = ip; s = 2'd1; end
      else if (req == 2'd1) begin e = sp; s = 2'd2; end
      else if (req == 2'd3) begin e = di; s = 2'd0; end
      else if (mode[4])     begin e = 16'h0; s = 2'd3; end
      else begin
         if (g == 2'd0)
            e = (l == 0) ? disp : (l == 1) ? bx : (l == 2) ? si : di;
         else if (g == 2'd1) begin
            e = ((l == 0) ? bx : (l == 1) ? bp : (l == 2) ? si : di) + dx;
            bpb = (l == 1);
         end else begin
            e = (l[1] ? bp : bx) + (l[0] ? di : si) + ((g == 2'd3) ? dx : 16'h0);
            bpb = l[1];
         end
         s = ovr[2] ? ovr[1:0] : (bpb ? 2'd2 : 2'd3);
      end
      sv = (s == 0) ? es : (s == 1) ? cs : (s == 2) ? ss : ds;
      return {s, e, 20'({4'h0, sv} * 20'd16 + {4'h0, e})};
   endfunction

   task automatic check(input string tag, input logic [37:0] exp);
      n_chk++;
      if ({seg, ea, pa} !== exp) begin
         n_fail++;
         $display("FAIL %s req=%0d mode=%0d ovr=%0d wide=%0b actual seg=%0d ea=%h pa=%h expected seg=%0d ea=%h pa=%h",
                  tag, req, mode, ovr, wide, seg, ea, pa, exp[37:36], exp[35:20], exp[19:0]);
      end
   endtask

   function automatic string pick_tag();
      if (req == 2'd0) return "R2";
      if (req == 2'd1) return "R3";
      if (req == 2'd3) return "R6";
      if (mode[4])     return "R10";
      if (ovr[2])      return "R7";
      if (!wide && mode[2]) return "R8";
      if (mode[3] || mode[2]) return "R9/R5";
      return "R4";
   endfunction

   task automatic load_set(input int k);
      case (k)
         0: begin
            cs = 16'h2500; ss = 16'h3000; ds = 16'h7000; es = 16'h5D27;
            bx = 16'h1234; bp = 16'h1234; si = 16'h0500; di = 16'h0012;
            ip = 16'h0002; sp = 16'hFFFE; disp = 16'h000A;
         end
         1: begin  // drives both sums past their wrap points (R9)
            cs = 16'hFFFF; ss = 16'hF000; ds = 16'hFFFE; es = 16'h8000;
            bx = 16'hFFF0; bp = 16'hFF80; si = 16'h8001; di = 16'h7FFF;
            ip = 16'hFFFF; sp = 16'h0000; disp = 16'h00F6;
         end
         default: begin  // short displacement with sign bit set (R8)
            cs = 16'h1111; ss = 16'h2222; ds = 16'h3333; es = 16'h4444;
            bx = 16'h0100; bp = 16'h0200; si = 16'h0030; di = 16'h0004;
            ip = 16'hABCD; sp = 16'h5678; disp = 16'h1280;
         end
      endcase
   endtask

   initial begin
      cs = '0; ss = '0; ds = '0; es = '0; bx = '0; bp = '0; si = '0; di = '0;
      ip = '0; sp = '0; disp = '0; wide = 0; mode = '0; ovr = '0; req = '0;
      #(CLK_P/4);
      // Idle state: all-zero inputs give fetch at 00000h (R1, R2)
      check("R1 idle", {2'd1, 16'h0, 20'h0});

      for (int k = 0; k < 3; k++) begin
         for (int r = 0; r < 4; r++) begin
            for (int m = 0; m < 32; m++) begin
               for (int o = 0; o < 8; o++) begin
                  for (int w = 0; w < 2; w++) begin
                     @(negedge clk);
                     load_set(k);
                     req = 2'(r); mode = 5'(m); ovr = 3'(o); wide = w[0];
                     #(CLK_P/4);
                     check(pick_tag(), expect_addr());
                  end
               end
            end
         end
      end

      // Worked vector: BX 0500 + DI 0012 + 0Ah in DS 7000 -> 7051Ch (R4, R1)
      @(negedge clk);
      load_set(0); bx = 16'h0500; req = 2'd2; mode = 5'd13; ovr = 3'd0; wide = 0;
      #(CLK_P/4);
      check("R4 vector", {2'd3, 16'h051C, 20'h7051C});

      // BP 1234 relative, zero displacement, SS 3000 -> 31234h (R5, R1)
      @(negedge clk);
      load_set(0); disp = 16'h0; req = 2'd2; mode = 5'd5; ovr = 3'd0; wide = 0;
      #(CLK_P/4);
      check("R5 vector", {2'd2, 16'h1234, 20'h31234});

      // Top-of-memory wrap: FFFF:0010 -> 00000h (R9)
      @(negedge clk);
      load_set(0); ds = 16'hFFFF; disp = 16'h0010; req = 2'd2; mode = 5'd0; ovr = 3'd0;
      #(CLK_P/4);
      check("R9 pa wrap", {2'd3, 16'h0010, 20'h00000});

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule